// File: doc/BRIEF.md
# Vector Multiply-Accumulate Unit

This unit runs the multiply group of a small vector coprocessor. It accepts one 32-bit instruction word through a valid/ready handshake. It then works through a run of consecutive registers in a 128-entry, 32-bit register file that sits outside the unit, at one element per clock. Each element reads operand A and operand B through two combinational read ports, forms a product, scales it down by 0, 8 or 16 bits, and writes the result back through a single write port. A write commits on the clock edge, so a later element of the same instruction sees the values that earlier elements wrote.

There are three operations. A plain multiply writes one product per element. A dot product sums the scaled products of all elements into one register. A scaled add multiplies A by the low half of register 1 and then adds B. Register 0 reads as zero and never accepts a write. An encoding the unit does not support raises a one-cycle flag and leaves the file untouched.

Top module: `vmac_unit`

## Requirements
- R1: `instrReady` is high while idle, and a word is accepted on a clock edge where `instrValid` and `instrReady` are both high. A legal word with count field c drops `instrReady` for exactly c+1 cycles, one per element. `instrReady` returns high in the cycle after the last element's write.
- R2: The word fields are: bits 31:28 width/shift mode, bits 27:24 count, bit 23 round, bits 22:21 operation, bits 20:14 A start index, bits 13:7 destination start index, bits 6:0 B start index.
- R3: Modes 0, 1 and 2 multiply the low 16 bits of A by the low 16 bits of the second factor, both unsigned, and shift right by 0, 8 and 16. Modes 4, 5 and 6 use all 32 bits of A with the same three shifts. The result is truncated to 32 bits.
- R4: With the round bit set and a nonzero shift, half the weight of the lowest kept bit is added to the product before the shift. With a shift of 0 the round bit has no effect.
- R5: Operation 0 (multiply) writes the scaled product of element e to destination+e. Element e uses A index A+e and B index B+e, all taken modulo 128.
- R6: Operation 1 (dot product) writes nothing until the last element. It then makes one write, the 32-bit sum of all scaled products, to the destination start index.
- R7: Operation 2 (scaled add) writes to destination+e the scaled product of A and the low 16 bits of register 1 (taken from `scalarLow`), plus the full 32-bit B operand.
- R8: A source index of 0 reads as zero, whatever the file returns for it.
- R9: A result whose destination is register 0 is discarded, and `wrEn` is never high with `wrAddr` 0.
- R10: A mode outside {0,1,2,4,5,6} or an operation value of 3 is accepted. It raises `illegalOp` for exactly the one cycle after acceptance, makes no write, and keeps `instrReady` high.
- R11: After reset `instrReady` is high and `wrEn` and `illegalOp` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | Instruction word offered |
| instrReady | output | 1 | Unit idle and able to take a word |
| instrWord | input | 32 | Multiply-group instruction word |
| rdAddrA | output | 7 | Read port A index |
| rdDataA | input | 32 | Register file contents at `rdAddrA` |
| rdAddrB | output | 7 | Read port B index |
| rdDataB | input | 32 | Register file contents at `rdAddrB` |
| scalarLow | input | 16 | Low half of register 1 |
| wrEn | output | 1 | Write strobe to the register file |
| wrAddr | output | 7 | Write index |
| wrData | output | 32 | Write value |
| illegalOp | output | 1 | One-cycle pulse for an unsupported encoding |

## Verification
Some rules hold on every cycle, and the assertions check those: the flag and ready behaviour right after a word is accepted, the one-step advance of the element counter, ready coming back after the last element, and the fact that a zero shift makes the round bit irrelevant. The arithmetic itself needs the bench's scenarios. These cover each width and shift with and without rounding, dot sums, scaled adds, index wrap through register 0 on both reads and writes, and overlapping source and destination ranges where later elements read earlier results. The bench compares every write against a behavioural model and then checks the whole file.

// File: rtl/vmac_pkg.sv
package vmac_pkg;

  // instruction field positions (fixed by the encoding)
  localparam int unsigned F_MODE_LO = 28;
  localparam int unsigned F_CNT_LO  = 24;
  localparam int unsigned F_RND     = 23;
  localparam int unsigned F_OP_LO   = 21;
  localparam int unsigned F_SRCA_LO = 14;
  localparam int unsigned F_DST_LO  = 7;
  localparam int unsigned F_SRCB_LO = 0;

  typedef enum logic [1:0] {
    OP_MUL  = 2'd0,
    OP_DOT  = 2'd1,
    OP_SAXP = 2'd2,
    OP_BAD  = 2'd3
  } opKind_e;

  // decoded, latched configuration of the running instruction
  typedef struct packed {
    logic       wide;   // full-width A operand
    logic [1:0] shSel;  // shift select: 0, 1, 2 -> 0, 8, 16
    logic       rnd;
    opKind_e    op;
  } mulCfg_t;

  // per-cycle strobes from control to datapath
  typedef struct packed {
    logic active;
    logic first;
    logic last;
  } dpStrobe_t;

endpackage

// File: rtl/vmac_ctrl.sv
module vmac_ctrl
  import vmac_pkg::*;
#(
  parameter int unsigned IDX_W = 7,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             instrValid,
  input  logic [31:0]      instrWord,
  output logic             instrReady,
  output logic             illegalOp,
  output mulCfg_t          cfg,
  output dpStrobe_t        strobe,
  output logic [IDX_W-1:0] rdAddrA,
  output logic [IDX_W-1:0] rdAddrB,
  output logic             wrEn,
  output logic [IDX_W-1:0] wrAddr
);

  logic             active;
  logic [CNT_W-1:0] elemIdx;
  logic [CNT_W-1:0] lastIdx;
  logic [IDX_W-1:0] baseA, baseB, baseD;
  mulCfg_t          cfgQ;

  logic [3:0] modeF;
  logic [1:0] opF;
  logic       legal;
  logic       accept;
  logic       isLast;

  assign modeF  = instrWord[F_MODE_LO +: 4];
  assign opF    = instrWord[F_OP_LO +: 2];
  assign legal  = !modeF[3] && (modeF[1:0] != 2'b11) && (opF != 2'b11);
  assign accept = instrValid && !active;
  assign isLast = (elemIdx == lastIdx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active    <= 1'b0;
      illegalOp <= 1'b0;
      elemIdx   <= '0;
      lastIdx   <= '0;
      baseA     <= '0;
      baseB     <= '0;
      baseD     <= '0;
      cfgQ      <= '0;
    end else begin
      illegalOp <= accept && !legal;
      if (accept && legal) begin
        active  <= 1'b1;
        elemIdx <= '0;
        lastIdx <= instrWord[F_CNT_LO +: CNT_W];
        baseA   <= instrWord[F_SRCA_LO +: IDX_W];
        baseB   <= instrWord[F_SRCB_LO +: IDX_W];
        baseD   <= instrWord[F_DST_LO +: IDX_W];
        cfgQ    <= '{wide:  modeF[2],
                     shSel: modeF[1:0],
                     rnd:   instrWord[F_RND],
                     op:    opKind_e'(opF)};
      end else if (active) begin
        if (isLast) active  <= 1'b0;
        else        elemIdx <= elemIdx + 1'b1;
      end
    end
  end

  assign instrReady = !active;
  assign cfg        = cfgQ;
  assign strobe     = '{active: active, first: (elemIdx == '0), last: isLast};
  assign rdAddrA    = baseA + IDX_W'(elemIdx);
  assign rdAddrB    = baseB + IDX_W'(elemIdx);
  assign wrAddr     = (cfgQ.op == OP_DOT) ? baseD : baseD + IDX_W'(elemIdx);
  assign wrEn       = active && ((cfgQ.op != OP_DOT) || isLast) && (wrAddr != '0);

  // R10: an unsupported word flags once and leaves the unit idle
  p_illegal_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && instrReady && !legal) |=> (illegalOp && instrReady));

  // R1: a legal word makes the unit busy from the next cycle
  p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && instrReady && legal) |=> !instrReady);

  // R1: ready returns once the last element has been issued
  p_ready_after_last_r1: assert property (@(posedge clk) disable iff (!rstN)
    (active && isLast) |=> instrReady);

  // R5: elements advance one index per cycle
  p_step_by_one_r5: assert property (@(posedge clk) disable iff (!rstN)
    (active && !isLast) |=> (active && (elemIdx == $past(elemIdx) + 1'b1)));

endmodule

// File: rtl/vmac_dp.sv
module vmac_dp
  import vmac_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned HALF_W = 16,
  parameter int unsigned IDX_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  mulCfg_t           cfg,
  input  dpStrobe_t         strobe,
  input  logic [IDX_W-1:0]  rdAddrA,
  input  logic [IDX_W-1:0]  rdAddrB,
  input  logic [DATA_W-1:0] rdDataA,
  input  logic [DATA_W-1:0] rdDataB,
  input  logic [HALF_W-1:0] scalarLow,
  output logic [DATA_W-1:0] wrData
);

  localparam int unsigned PROD_W     = DATA_W + HALF_W;
  localparam int unsigned SUM_W      = PROD_W + 1;
  localparam int unsigned SHIFT_STEP = 8;

  logic [DATA_W-1:0] opA, opB, mulA;
  logic [HALF_W-1:0] mulB;
  logic [PROD_W-1:0] prod;
  logic [SUM_W-1:0]  rndBias, rounded, shifted;
  logic [DATA_W-1:0] res, accQ, sumIn, dotSum;
  int unsigned       shAmt;

  // register 0 always reads as zero
  assign opA = (rdAddrA == '0) ? '0 : rdDataA;
  assign opB = (rdAddrB == '0) ? '0 : rdDataB;

  assign mulA = cfg.wide ? opA : {{(DATA_W-HALF_W){1'b0}}, opA[HALF_W-1:0]};
  assign mulB = (cfg.op == OP_SAXP) ? scalarLow : opB[HALF_W-1:0];
  assign prod = PROD_W'(mulA) * PROD_W'(mulB);

  always_comb begin
    shAmt   = 32'(cfg.shSel) * SHIFT_STEP;
    rndBias = (cfg.rnd && (cfg.shSel != 2'd0)) ? ((SUM_W'(1) << shAmt) >> 1) : '0;
    rounded = {1'b0, prod} + rndBias;
    shifted = rounded >> shAmt;
    res     = shifted[DATA_W-1:0];
  end

  assign sumIn  = strobe.first ? '0 : accQ;
  assign dotSum = sumIn + res;

  always_ff @(posedge clk) begin
    if (!rstN)              accQ <= '0;
    else if (strobe.active) accQ <= dotSum;
  end

  always_comb begin
    case (cfg.op)
      OP_DOT:  wrData = dotSum;
      OP_SAXP: wrData = res + opB;
      default: wrData = res;
    endcase
  end

  // R4: with no shift the round request cannot change the product
  p_shift0_exact_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.active && (cfg.shSel == 2'd0)) |-> (res == prod[DATA_W-1:0]));

endmodule

// File: rtl/vmac_unit.sv
module vmac_unit
  import vmac_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned HALF_W = 16,
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  output logic              instrReady,
  input  logic [31:0]       instrWord,
  output logic [IDX_W-1:0]  rdAddrA,
  input  logic [DATA_W-1:0] rdDataA,
  output logic [IDX_W-1:0]  rdAddrB,
  input  logic [DATA_W-1:0] rdDataB,
  input  logic [HALF_W-1:0] scalarLow,
  output logic              wrEn,
  output logic [IDX_W-1:0]  wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              illegalOp
);

  mulCfg_t   cfg;
  dpStrobe_t strobe;

  vmac_ctrl #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .instrValid(instrValid), .instrWord(instrWord),
    .instrReady(instrReady), .illegalOp(illegalOp),
    .cfg(cfg), .strobe(strobe),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
    .wrEn(wrEn), .wrAddr(wrAddr)
  );

  vmac_dp #(.DATA_W(DATA_W), .HALF_W(HALF_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .cfg(cfg), .strobe(strobe),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
    .rdDataA(rdDataA), .rdDataB(rdDataB),
    .scalarLow(scalarLow), .wrData(wrData)
  );

endmodule

// File: tb/tb_vmac_unit.sv
`timescale 1ns/1ps
module tb_vmac_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic        instrReady, wrEn, illegalOp;
  logic [6:0]  rdAddrA, rdAddrB, wrAddr;
  logic [31:0] rdDataA, rdDataB, wrData;
  logic [15:0] scalarLow;

  always #2.5 clk = ~clk;

  // bench-side register file (reg 0 holds garbage on purpose)
  logic [31:0] mem    [128];
  logic [31:0] refMem [128];

  assign rdDataA   = mem[rdAddrA];
  assign rdDataB   = mem[rdAddrB];
  assign scalarLow = mem[1][15:0];

  always @(posedge clk) if (wrEn) mem[wrAddr] <= wrData;

  vmac_unit dut (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrReady(instrReady),
    .instrWord(instrWord), .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB), .scalarLow(scalarLow),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .illegalOp(illegalOp)
  );

  typedef struct { logic [6:0] a; logic [31:0] d; } wr_t;
  wr_t   expQ[$];
  int    compared = 0;
  int    mismatched = 0;
  string curTag = "R11";
  bit    finished = 0;

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // every-clock comparison of the write port against the model queue
  always @(negedge clk) begin : mon
    wr_t e;
    if (rstN && wrEn) begin
      if (expQ.size() == 0) begin
        check(0, curTag, "unexpected write (R9/R10)", {25'd0, wrAddr}, 32'hFFFF_FFFF);
      end else begin
        e = expQ.pop_front();
        check(wrAddr == e.a, curTag, "write addr", {25'd0, wrAddr}, {25'd0, e.a});
        check(wrData == e.d, curTag, "write data", wrData, e.d);
      end
    end
  end

  function automatic logic [31:0] mulRef(int mode, bit rnd, logic [31:0] a, logic [31:0] b);
    longint unsigned x, p;
    int sh;
    sh = (mode % 4) * 8;
    x  = (mode >= 4) ? a : (a & 32'h0000_FFFF);
    p  = x * (b & 32'h0000_FFFF);
    if (rnd && sh > 0) p = p + (64'd1 << (sh - 1));
    p = p >> sh;
    return p[31:0];
  endfunction

  function automatic logic [31:0] rdv(int i);
    return (i == 0) ? 32'd0 : refMem[i];
  endfunction

  task automatic expWrite(int idx, logic [31:0] v);
    wr_t e;
    if (idx != 0) begin
      e.a = 7'(idx);
      e.d = v;
      expQ.push_back(e);
      refMem[idx] = v;
    end
  endtask

  task automatic run(int mode, bit rnd, int op, int cnt, int a, int d, int b, string tag);
    logic [31:0] word, av, bv, r, sum;
    bit legal;
    int n, bad;
    word  = {4'(mode), 4'(cnt), rnd, 2'(op), 7'(a), 7'(d), 7'(b)};
    legal = (mode inside {0, 1, 2, 4, 5, 6}) && (op != 3);
    sum   = '0;
    if (legal) begin
      for (int e = 0; e <= cnt; e++) begin
        av = rdv((a + e) % 128);
        bv = rdv((b + e) % 128);
        if (op == 0) expWrite((d + e) % 128, mulRef(mode, rnd, av, bv));
        else if (op == 2) begin
          r = mulRef(mode, rnd, av, refMem[1]) + bv;
          expWrite((d + e) % 128, r);
        end else begin
          sum = sum + mulRef(mode, rnd, av, bv);
          if (e == cnt) expWrite(d, sum);
        end
      end
    end
    @(negedge clk);
    curTag     = tag;
    instrValid = 1'b1;
    instrWord  = word;
    @(negedge clk);
    instrValid = 1'b0;
    if (!legal) begin
      check(illegalOp == 1'b1, "R10", "illegal flag", {31'd0, illegalOp}, 32'd1);
      check(instrReady == 1'b1, "R10", "ready kept", {31'd0, instrReady}, 32'd1);
      @(negedge clk);
      check(illegalOp == 1'b0, "R10", "flag one cycle", {31'd0, illegalOp}, 32'd0);
    end else begin
      check(illegalOp == 1'b0, tag, "no flag (R10)", {31'd0, illegalOp}, 32'd0);
      n = 0;
      while (!instrReady && n < 64) begin
        n++;
        @(negedge clk);
      end
      check(n == cnt + 1, "R1", "busy cycles", 32'(n), 32'(cnt + 1));
    end
    check(expQ.size() == 0, tag, "pending writes", 32'(expQ.size()), 32'd0);
    expQ.delete();
    bad = 0;
    for (int i = 0; i < 128; i++) if (mem[i] !== refMem[i]) bad++;
    check(bad == 0, tag, "file contents", 32'(bad), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) begin
      mem[i]    = (32'(i) * 32'h9E37_79B1) ^ 32'h5A17_C3E9;
      refMem[i] = mem[i];
    end
    mem[0] = 32'hDEAD_BEEF;  refMem[0] = 32'hDEAD_BEEF;
    mem[1] = 32'h0000_8123;  refMem[1] = 32'h0000_8123;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R11 reset state
    check(instrReady == 1'b1, "R11", "ready", {31'd0, instrReady}, 32'd1);
    check(wrEn == 1'b0, "R11", "wrEn", {31'd0, wrEn}, 32'd0);
    check(illegalOp == 1'b0, "R11", "illegalOp", {31'd0, illegalOp}, 32'd0);

    run(0, 0, 0, 3, 10, 40, 20, "R5");     // R2 R3 16x16 no shift
    run(1, 0, 0, 2, 11, 50, 21, "R3");     // 16x16 >> 8
    run(1, 1, 0, 2, 11, 54, 21, "R4");     // rounded >> 8
    run(2, 1, 0, 4, 30, 60, 35, "R4");     // rounded >> 16
    run(2, 0, 0, 4, 30, 66, 35, "R3");     // >> 16 truncating
    run(4, 0, 0, 3, 12, 70, 22, "R3");     // 32x16 no shift, truncated
    run(5, 1, 0, 3, 12, 74, 22, "R4");     // 32x16 >> 8 rounded
    run(6, 1, 0, 3, 13, 78, 23, "R4");     // 32x16 >> 16 rounded
    run(0, 1, 0, 3, 10, 82, 20, "R4");     // round with zero shift: no effect
    run(0, 0, 1, 5, 14, 90, 24, "R6");     // dot product
    run(5, 1, 1, 15, 3, 91, 100, "R6");    // dot, max count
    run(1, 1, 2, 3, 15, 95, 25, "R7");     // scaled add
    run(4, 0, 2, 0, 16, 99, 26, "R7");     // scaled add, single element
    run(4, 0, 0, 3, 126, 102, 0, "R8");    // A wraps through 0, B starts at 0
    run(0, 0, 0, 2, 5, 127, 9, "R9");      // dest wraps through 0
    run(0, 0, 1, 2, 5, 0, 9, "R9");        // dot to register 0 discarded
    run(4, 0, 0, 6, 40, 41, 45, "R5");     // overlapping: reads prior results
    run(3, 0, 0, 2, 10, 20, 30, "R10");    // bad mode 3
    run(7, 0, 0, 2, 10, 20, 30, "R10");    // bad mode 7
    run(9, 0, 0, 2, 10, 20, 30, "R10");    // bad mode 9
    run(0, 0, 3, 2, 10, 20, 30, "R10");    // bad operation 3
    run(2, 0, 0, 1, 60, 110, 61, "R1");    // legal again after illegal
    check(mem[0] === 32'hDEAD_BEEF, "R9", "reg0 untouched", mem[0], 32'hDEAD_BEEF);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL R1 watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule